// File: doc/BRIEF.md
# Multi-Latency Non-Pipelined Execute Stage

This block is the execute stage of a small in-order integer pipeline. Decode hands it one decoded instruction at a time: an operation code, a destination register index, two register operands, a 16-bit immediate and the instruction's program counter. The unit holds that instruction for a number of cycles that depends on the operation, then passes the result on to the memory stage. A multiply takes `MUL_LAT` cycles and every other operation takes `BASE_LAT` cycles. A down-counter that is loaded at acceptance tracks the cycles that remain.

Only one instruction can be inside the unit at a time. The decode side is a valid/ready port. `in_ready` is high only while the unit is empty, so a new instruction is taken no earlier than the cycle after the previous one has left. The memory side is also valid/ready. Once `out_valid` is raised it stays raised, with stable fields, until the cycle in which `out_ready` is high. While it waits, the unit stays busy and refuses new work.

Branch-if-equal is resolved inside the unit by subtracting one operand from the other. On its final cycle the unit raises a one-cycle resolve pulse for the fetch and decode logic, together with a taken flag and a target address. A branch never enters the memory latch.

Top module: `mcx_exec`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `br_resolve` are 0.
- R2: The operation codes on `in_op` are: 0 add (a+b), 1 subtract (a-b), 2 add-immediate (a+sext(imm)), 3 multiply (low 32 bits of a*b), 4 load, 5 store, 6 branch-if-equal, 7 no-op. The arithmetic codes 0 to 3 deliver their result on `out_result` with `out_wen`=1, `out_mem_rd`=0, `out_mem_wr`=0, and carry `in_rd` to `out_rd`.
- R3: The instruction is accepted on a clock edge. For a multiply, its final cycle (`out_valid` high) is the MUL_LAT-th cycle after that edge. For every other code, the final cycle is the BASE_LAT-th cycle after that edge.
- R4: From the acceptance edge until the edge on which the instruction leaves, `in_ready` is 0 and `in_valid` is ignored. The instruction leaves on that edge, and `in_ready` is 1 in the cycle after it.
- R5: Load and store put the address a+sext(imm) on `out_result`. A load drives `out_wen`=1 and `out_mem_rd`=1. A store drives `out_wen`=0 and `out_mem_wr`=1, and puts operand b on `out_store_data`.
- R6: Branch-if-equal raises `br_resolve` for exactly one cycle, its final cycle. `br_taken` is 1 exactly when a-b is zero. `br_target` = pc+4+(sext(imm)<<2). The unit then leaves without raising `out_valid`, whatever the value of `out_ready`.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, all output fields stay stable, and `in_ready` stays 0.
- R8: A no-op (code 7) occupies the unit for BASE_LAT cycles and raises neither `out_valid` nor `br_resolve`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Unit is empty and takes the offer |
| in_op | input | 3 | Operation code (see R2) |
| in_rd | input | 5 | Destination register index |
| in_a | input | DW | First operand / base register |
| in_b | input | DW | Second operand / store data |
| in_imm | input | 16 | Immediate, sign-extended inside |
| in_pc | input | DW | Program counter of the instruction |
| out_valid | output | 1 | Result offered to the memory latch |
| out_ready | input | 1 | Memory latch takes the result |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Result must be written back |
| out_mem_rd | output | 1 | Memory stage must read |
| out_mem_wr | output | 1 | Memory stage must write |
| out_result | output | DW | ALU result or data memory address |
| out_store_data | output | DW | Data to be stored |
| br_resolve | output | 1 | One-cycle branch resolution pulse |
| br_taken | output | 1 | Branch taken (valid with br_resolve) |
| br_target | output | DW | Branch target (valid with br_resolve) |

## Verification
The hardest situation to reach is a finished memory-bound result that is held back. In that state the memory latch refuses the result while decode keeps offering a different instruction. The bench creates it by lowering `out_ready` for one to three cycles on a rotating subset of instructions. During the whole occupancy it keeps `in_valid` high with a conflicting multiply. It then checks that the held fields never move and that the intruder is not taken until the cycle after the result leaves. Each of the eight operation codes is swept against six operand pairs and five immediates. The operand pairs include equal, wrapping and sign-boundary values. The immediates include 0x8000 and 0xFFFF.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ADDI  = 3'd2,
    OP_MUL   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_BEQ   = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  localparam int unsigned IMM_W = 16;
  localparam int unsigned REG_W = 5;

  function automatic int unsigned lat_width(input int unsigned a, input int unsigned b);
    int unsigned mx;
    mx = (a > b) ? a : b;
    return $clog2(mx + 1);
  endfunction

endpackage

// File: rtl/mcx_countdown.sv
module mcx_countdown #(
  parameter int unsigned MUL_LAT  = 4,
  parameter int unsigned BASE_LAT = 2,
  parameter int unsigned CW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic is_mul,
  input  logic leave,
  output logic busy,
  output logic last
);
  localparam logic [CW-1:0] MUL_C  = CW'(MUL_LAT);
  localparam logic [CW-1:0] BASE_C = CW'(BASE_LAT);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] remain_q;
  logic [CW-1:0] load_val;

  assign load_val = is_mul ? MUL_C : BASE_C;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (leave) begin
      remain_q <= '0;
    end else if (remain_q > ONE_C) begin
      remain_q <= remain_q - ONE_C;
    end
  end

  assign busy = (remain_q != '0);
  assign last = (remain_q == ONE_C);

  // R3: the counter starts at the latency chosen for the operation
  p_load_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain_q == $past(load_val));

  // R3: one step down per cycle until the final cycle
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q > ONE_C) && !load |=> remain_q == $past(remain_q) - ONE_C);

  // R7: a waiting final cycle does not advance
  p_final_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last && !leave |=> last);

endmodule

// File: rtl/mcx_alu.sv
module mcx_alu
  import mcx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  op_e              op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    pc,
  output logic [DW-1:0]    result,
  output logic             wen,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             to_mem,
  output logic             is_branch,
  output logic             taken,
  output logic [DW-1:0]    target
);
  logic [DW-1:0] simm;
  logic [DW-1:0] diff;
  logic [DW-1:0] sum_ab;
  logic [DW-1:0] sum_ai;
  logic [DW-1:0] prod;

  assign simm   = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
  assign diff   = a - b;
  assign sum_ab = a + b;
  assign sum_ai = a + simm;
  assign prod   = a * b;

  always_comb begin
    result    = '0;
    wen       = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    to_mem    = 1'b1;
    is_branch = 1'b0;
    unique case (op)
      OP_ADD:   begin result = sum_ab; wen = 1'b1; end
      OP_SUB:   begin result = diff;   wen = 1'b1; end
      OP_ADDI:  begin result = sum_ai; wen = 1'b1; end
      OP_MUL:   begin result = prod;   wen = 1'b1; end
      OP_LOAD:  begin result = sum_ai; wen = 1'b1; mem_rd = 1'b1; end
      OP_STORE: begin result = sum_ai; mem_wr = 1'b1; end
      OP_BEQ:   begin to_mem = 1'b0; is_branch = 1'b1; end
      OP_NOP:   begin to_mem = 1'b0; end
      default:  begin to_mem = 1'b0; end
    endcase
  end

  assign taken  = (diff == '0);
  assign target = pc + DW'(4) + {simm[DW-3:0], 2'b00};

endmodule

// File: rtl/mcx_exec.sv
module mcx_exec
  import mcx_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned MUL_LAT  = 4,
  parameter int unsigned BASE_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [REG_W-1:0] in_rd,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [DW-1:0]    in_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [REG_W-1:0] out_rd,
  output logic             out_wen,
  output logic             out_mem_rd,
  output logic             out_mem_wr,
  output logic [DW-1:0]    out_result,
  output logic [DW-1:0]    out_store_data,
  output logic             br_resolve,
  output logic             br_taken,
  output logic [DW-1:0]    br_target
);
  localparam int unsigned CW = lat_width(MUL_LAT, BASE_LAT);

  op_e              op_q;
  logic [REG_W-1:0] rd_q;
  logic [DW-1:0]    a_q, b_q, pc_q;
  logic [IMM_W-1:0] imm_q;

  logic accept, leave, busy, last;
  logic to_mem, is_branch;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_NOP;
      rd_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      imm_q <= '0;
      pc_q  <= '0;
    end else if (accept) begin
      op_q  <= op_e'(in_op);
      rd_q  <= in_rd;
      a_q   <= in_a;
      b_q   <= in_b;
      imm_q <= in_imm;
      pc_q  <= in_pc;
    end
  end

  mcx_countdown #(
    .MUL_LAT (MUL_LAT),
    .BASE_LAT(BASE_LAT),
    .CW      (CW)
  ) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .is_mul(in_op == OP_MUL),
    .leave (leave),
    .busy  (busy),
    .last  (last)
  );

  mcx_alu #(.DW(DW)) alu_i (
    .op       (op_q),
    .a        (a_q),
    .b        (b_q),
    .imm      (imm_q),
    .pc       (pc_q),
    .result   (out_result),
    .wen      (out_wen),
    .mem_rd   (out_mem_rd),
    .mem_wr   (out_mem_wr),
    .to_mem   (to_mem),
    .is_branch(is_branch),
    .taken    (br_taken),
    .target   (br_target)
  );

  assign out_store_data = b_q;
  assign out_rd         = rd_q;
  assign out_valid      = last && to_mem;
  assign br_resolve     = last && is_branch;
  assign leave          = last && (!to_mem || out_ready);

  // R4: an accepted instruction closes the input port at once
  p_one_inflight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7: a refused result is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_rd) && $stable(out_store_data) && !in_ready);

  // R6: resolution is a single-cycle pulse
  p_resolve_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_resolve |=> !br_resolve);

  // R6: taken exactly when the operands are equal
  p_taken_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_resolve |-> br_taken == (a_q == b_q));

  // R6: branches never appear at the memory latch
  p_br_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_resolve && out_valid));

endmodule

// File: tb/mcx_exec_tb_top.sv
module mcx_exec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ML = 3;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_op = '0;
  logic [4:0] in_rd = '0;
  logic [31:0] in_a = '0, in_b = '0, in_pc = '0;
  logic [15:0] in_imm = '0;
  logic in_ready, out_valid, out_wen, out_mem_rd, out_mem_wr;
  logic [4:0] out_rd;
  logic [31:0] out_result, out_store_data, br_target;
  logic br_resolve, br_taken;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcx_exec #(.DW(32), .MUL_LAT(ML), .BASE_LAT(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd),
    .out_wen(out_wen), .out_mem_rd(out_mem_rd), .out_mem_wr(out_mem_wr),
    .out_result(out_result), .out_store_data(out_store_data),
    .br_resolve(br_resolve), .br_taken(br_taken), .br_target(br_target)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input logic [31:0] pc,
                        input logic [4:0] rd, input int stall);
    int lat;
    bit tomem;
    logic [31:0] er;
    lat = (op == 3) ? ML : NL;
    tomem = (op <= 5);
    case (op)
      0: er = a + b;
      1: er = a - b;
      2, 4, 5: er = a + sx(imm);
      3: er = a * b;
      default: er = '0;
    endcase
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready before offer", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_op = op[2:0]; in_a = a; in_b = b; in_imm = imm;
    in_pc = pc; in_rd = rd;
    out_ready = (stall == 0);
    @(posedge clk);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      // conflicting offer held during occupancy (R4)
      in_op = 3'd3; in_a = ~a; in_b = 32'h1234_5678; in_rd = ~rd;
      if (k < lat) begin
        chk(!out_valid && !br_resolve, "R3 early completion",
            {30'd0, out_valid, br_resolve}, 32'd0);
        chk(!in_ready, "R4 busy", {31'd0, in_ready}, 32'd0);
      end
    end
    if (tomem) begin
      chk(out_valid, "R3 final cycle valid", {31'd0, out_valid}, 32'd1);
      chk(out_result == er, (op >= 4) ? "R5 address" : "R2 result", out_result, er);
      chk(out_rd == rd, "R2 rd", {27'd0, out_rd}, {27'd0, rd});
      chk(out_wen == (op != 5), "R2/R5 wen", {31'd0, out_wen}, {31'd0, op != 5});
      chk(out_mem_rd == (op == 4) && out_mem_wr == (op == 5), "R5 mem flags",
          {30'd0, out_mem_rd, out_mem_wr}, {30'd0, op == 4, op == 5});
      if (op == 5) chk(out_store_data == b, "R5 store data", out_store_data, b);
      chk(!br_resolve, "R6 no resolve", {31'd0, br_resolve}, 32'd0);
      for (int s = 0; s < stall; s++) begin
        @(posedge clk); @(negedge clk);
        chk(out_valid && out_result == er && !in_ready, "R7 hold",
            out_result, er);
      end
    end else if (op == 6) begin
      chk(br_resolve && !out_valid, "R6 resolve", {30'd0, br_resolve, out_valid}, 32'd2);
      chk(br_taken == (a == b), "R6 taken", {31'd0, br_taken}, {31'd0, a == b});
      chk(br_target == pc + 32'd4 + (sx(imm) << 2), "R6 target", br_target,
          pc + 32'd4 + (sx(imm) << 2));
    end else begin
      chk(!out_valid && !br_resolve, "R8 nop silent",
          {30'd0, out_valid, br_resolve}, 32'd0);
    end
    out_ready = 1'b1; in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(in_ready && !out_valid && !br_resolve, "R4 free after leave",
        {29'd0, in_ready, out_valid, br_resolve}, 32'd4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [15:0] im [5];
    int n;
    pa = '{32'd0, 32'd5, 32'd7, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1357_9BDF};
    pb = '{32'd0, 32'd5, 32'd3, 32'd1, 32'd2, 32'h0246_8ACE};
    im = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state (rst_n still low)
    chk(in_ready && !out_valid && !br_resolve, "R1 reset",
        {29'd0, in_ready, out_valid, br_resolve}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !br_resolve, "R1 after reset",
        {29'd0, in_ready, out_valid, br_resolve}, 32'd4);
    n = 0;
    for (int op = 0; op < 8; op++)
      for (int p = 0; p < 6; p++)
        for (int i = 0; i < 5; i++) begin
          run_op(op, pa[p], pb[p], im[i], 32'h0000_1000 + 32'(n * 4),
                 5'(n + 1), n % 4);
          n++;
        end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule